// File: doc/BRIEF.md
# Sub-word Addressable Register File

This block holds eight 32-bit general registers for a datapath that works on several operand widths. Each register can be accessed as a full 32-bit value, as its low 16-bit half, or as one of the two bytes that make up that low half. A narrow write changes only the slice it addresses. All other bits of the register keep their previous value. This lets an execution unit update part of a register without first reading the whole register back.

The block has one clocked write port and two combinational read ports. All three ports take the same addressing fields: a register index, a two-bit view select and a byte-high flag. Byte views exist only on the lower half of the register set. In byte view, index values in the upper half of the range name the high byte of the matching lower register. A narrow read returns the selected slice zero-extended to the full width. Writes land at the clock edge, so a read in the same cycle still sees the old contents.

Top module: `regfile_subword`

## Requirements
- R1: While the synchronous reset `rst` is high at a rising edge, every register is cleared to zero.
- R2: View code 2'b10 writes all 32 bits of the indexed register and reads all 32 bits.
- R3: View code 2'b01 writes bits 15:0 of the indexed register from `wr_data[15:0]` and leaves bits 31:16 unchanged.
- R4: View code 2'b00 with the high flag clear and an index below 4 writes bits 7:0 from `wr_data[7:0]` and leaves bits 31:8 unchanged.
- R5: View code 2'b00 with the high flag set targets bits 15:8 of register (index mod 4). A write takes `wr_data[7:0]` into that slice and leaves all other bits unchanged.
- R6: In view code 2'b00, an index of 4 to 7 selects bits 15:8 of register (index minus 4), whatever the high flag says. This holds for reads and writes alike.
- R7: A read in view 2'b01 or 2'b00 returns the slice in the low bits of the read data, with all upper bits zero.
- R8: Read ports are combinational. A read of the register being written in the same cycle returns the old value, and the new value appears after that rising edge.
- R9: When `wr_en` is low, no register changes.
- R10: The two read ports decode their own index, view and high flag independently of each other.
- R11: View code 2'b11 behaves exactly like view code 2'b10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 3 | Write register index |
| wr_view | input | 2 | Write view: 00 byte, 01 low half, 10/11 full |
| wr_hi | input | 1 | Write byte-high flag (byte view only) |
| wr_data | input | 32 | Write data, right-aligned for narrow views |
| ra_idx | input | 3 | Read port A register index |
| ra_view | input | 2 | Read port A view |
| ra_hi | input | 1 | Read port A byte-high flag |
| ra_data | output | 32 | Read port A data, zero-extended |
| rb_idx | input | 3 | Read port B register index |
| rb_view | input | 2 | Read port B view |
| rb_hi | input | 1 | Read port B byte-high flag |
| rb_data | output | 32 | Read port B data, zero-extended |

## Verification
The bench builds the block with its defaults: eight registers, 32 bits wide. This puts the full byte-index range 0 to 7 within reach, including the fold of indices 4 to 7 onto the high bytes of registers 0 to 3. It also reaches both byte positions inside the low half and the reserved view code. Merge sequences on a single register confirm that each narrow write preserves the bits written earlier at other widths. The two ports are driven with different addressing in the same cycle, and a same-cycle write and read shows the old-value-then-new timing.

// File: rtl/regfile_pkg.sv
package regfile_pkg;

    // Access width selector shared by the write and read ports
    typedef enum logic [1:0] {
        VIEW_BYTE = 2'b00,
        VIEW_HALF = 2'b01,
        VIEW_FULL = 2'b10,
        VIEW_RSVD = 2'b11
    } view_e;

endpackage

// File: rtl/rf_slice_decode.sv
module rf_slice_decode
    import regfile_pkg::*;
#(
    parameter int NUM_REGS = 8,
    parameter int DATA_W   = 32,
    localparam int IDX_W   = $clog2(NUM_REGS),
    localparam int SH_W    = $clog2(DATA_W)
) (
    input  logic [IDX_W-1:0]  idx,
    input  view_e             view,
    input  logic              hi,
    output logic [IDX_W-1:0]  eff_idx,
    output logic [DATA_W-1:0] mask,
    output logic [SH_W-1:0]   shamt
);
    localparam int HALF_W    = DATA_W / 2;
    localparam int BYTE_W    = DATA_W / 4;
    localparam int BYTE_REGS = NUM_REGS / 2;
    localparam logic [DATA_W-1:0] BYTE_MASK = {{(DATA_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}};
    localparam logic [DATA_W-1:0] HALF_MASK = {{(DATA_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};

    logic upper_byte;

    always_comb begin
        eff_idx    = idx;
        mask       = '1;
        shamt      = '0;
        upper_byte = 1'b0;
        case (view)
            VIEW_BYTE: begin
                // indices past the byte-capable range fold onto high bytes
                upper_byte = hi | (idx >= IDX_W'(BYTE_REGS));
                eff_idx    = idx & IDX_W'(BYTE_REGS - 1);
                shamt      = upper_byte ? SH_W'(BYTE_W) : '0;
                mask       = upper_byte ? (BYTE_MASK << BYTE_W) : BYTE_MASK;
            end
            VIEW_HALF: mask = HALF_MASK;
            default:   mask = '1;
        endcase
    end
endmodule

// File: rtl/rf_read_port.sv
module rf_read_port
    import regfile_pkg::*;
#(
    parameter int NUM_REGS = 8,
    parameter int DATA_W   = 32,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic [NUM_REGS-1:0][DATA_W-1:0] regs,
    input  logic [IDX_W-1:0]                idx,
    input  view_e                           view,
    input  logic                            hi,
    output logic [DATA_W-1:0]               data
);
    localparam int SH_W = $clog2(DATA_W);

    logic [IDX_W-1:0]  eff_idx;
    logic [DATA_W-1:0] mask;
    logic [SH_W-1:0]   shamt;

    rf_slice_decode #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_dec (
        .idx     (idx),
        .view    (view),
        .hi      (hi),
        .eff_idx (eff_idx),
        .mask    (mask),
        .shamt   (shamt)
    );

    assign data = (regs[eff_idx] & mask) >> shamt;
endmodule

// File: rtl/rf_write_merge.sv
module rf_write_merge #(
    parameter int DATA_W = 32,
    localparam int SH_W  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] old_val,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] mask,
    input  logic [SH_W-1:0]   shamt,
    output logic [DATA_W-1:0] new_val
);
    assign new_val = (old_val & ~mask) | ((wdata << shamt) & mask);
endmodule

// File: rtl/regfile_subword.sv
module regfile_subword
    import regfile_pkg::*;
#(
    parameter int NUM_REGS = 8,
    parameter int DATA_W   = 32,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [1:0]        wr_view,
    input  logic              wr_hi,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  ra_idx,
    input  logic [1:0]        ra_view,
    input  logic              ra_hi,
    output logic [DATA_W-1:0] ra_data,
    input  logic [IDX_W-1:0]  rb_idx,
    input  logic [1:0]        rb_view,
    input  logic              rb_hi,
    output logic [DATA_W-1:0] rb_data
);
    localparam int SH_W   = $clog2(DATA_W);
    localparam int NUM_RD = 2;

    typedef struct packed {
        logic [NUM_REGS-1:0][DATA_W-1:0] regs;
    } rf_state_t;

    rf_state_t st_d, st_q;

    // write path
    logic [IDX_W-1:0]  w_eff_d;
    logic [DATA_W-1:0] w_mask_d;
    logic [SH_W-1:0]   w_shamt_d;
    logic [DATA_W-1:0] w_merged_d;

    rf_slice_decode #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_wdec (
        .idx     (wr_idx),
        .view    (view_e'(wr_view)),
        .hi      (wr_hi),
        .eff_idx (w_eff_d),
        .mask    (w_mask_d),
        .shamt   (w_shamt_d)
    );

    rf_write_merge #(.DATA_W(DATA_W)) u_merge (
        .old_val (st_q.regs[w_eff_d]),
        .wdata   (wr_data),
        .mask    (w_mask_d),
        .shamt   (w_shamt_d),
        .new_val (w_merged_d)
    );

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d = '0;
        end else if (wr_en) begin
            st_d.regs[w_eff_d] = w_merged_d;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    // read paths
    logic [NUM_RD-1:0][IDX_W-1:0]  rp_idx;
    logic [NUM_RD-1:0][1:0]        rp_view;
    logic [NUM_RD-1:0]             rp_hi;
    logic [NUM_RD-1:0][DATA_W-1:0] rp_data;

    assign rp_idx  = {rb_idx, ra_idx};
    assign rp_view = {rb_view, ra_view};
    assign rp_hi   = {rb_hi, ra_hi};

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        rf_read_port #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_rd (
            .regs (st_q.regs),
            .idx  (rp_idx[p]),
            .view (view_e'(rp_view[p])),
            .hi   (rp_hi[p]),
            .data (rp_data[p])
        );
    end

    assign ra_data = rp_data[0];
    assign rb_data = rp_data[1];
endmodule

// File: rtl/rf_subword_checker.sv
module rf_subword_checker #(
    parameter int NUM_REGS = 8,
    parameter int DATA_W   = 32,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input logic                            clk,
    input logic                            rst,
    input logic                            wr_en,
    input logic [IDX_W-1:0]                wr_idx,
    input logic [1:0]                      wr_view,
    input logic                            wr_hi,
    input logic [1:0]                      ra_view,
    input logic [DATA_W-1:0]               ra_data,
    input logic [1:0]                      rb_view,
    input logic [DATA_W-1:0]               rb_data,
    input logic [NUM_REGS-1:0][DATA_W-1:0] regs
);
    localparam int HALF_W    = DATA_W / 2;
    localparam int BYTE_W    = DATA_W / 4;
    localparam int BYTE_REGS = NUM_REGS / 2;

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (regs == '0));

    p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(regs));

    p_half_keeps_upper_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_view == 2'b01)
        |=> regs[$past(wr_idx)][DATA_W-1:HALF_W] == $past(regs[wr_idx][DATA_W-1:HALF_W]));

    p_low_byte_keeps_rest_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_view == 2'b00 && !wr_hi && wr_idx < IDX_W'(BYTE_REGS))
        |=> regs[$past(wr_idx)][DATA_W-1:BYTE_W] == $past(regs[wr_idx][DATA_W-1:BYTE_W]));

    p_byte_read_zero_ext_r7: assert property (@(posedge clk) disable iff (rst)
        (ra_view == 2'b00) |-> ra_data[DATA_W-1:BYTE_W] == '0);

    p_half_read_zero_ext_r7: assert property (@(posedge clk) disable iff (rst)
        (rb_view == 2'b01) |-> rb_data[DATA_W-1:HALF_W] == '0);
endmodule

bind regfile_subword rf_subword_checker #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_view (wr_view),
    .wr_hi   (wr_hi),
    .ra_view (ra_view),
    .ra_data (ra_data),
    .rb_view (rb_view),
    .rb_data (rb_data),
    .regs    (st_q.regs)
);

// File: tb/tb_regfile_subword.sv
module tb_regfile_subword;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_idx = '0;
    logic [1:0]  wr_view = '0;
    logic        wr_hi = 1'b0;
    logic [31:0] wr_data = '0;
    logic [2:0]  ra_idx = '0;
    logic [1:0]  ra_view = 2'b10;
    logic        ra_hi = 1'b0;
    logic [31:0] ra_data;
    logic [2:0]  rb_idx = '0;
    logic [1:0]  rb_view = 2'b10;
    logic        rb_hi = 1'b0;
    logic [31:0] rb_data;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    regfile_subword dut (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_view(wr_view), .wr_hi(wr_hi), .wr_data(wr_data),
        .ra_idx(ra_idx), .ra_view(ra_view), .ra_hi(ra_hi), .ra_data(ra_data),
        .rb_idx(rb_idx), .rb_view(rb_view), .rb_hi(rb_hi), .rb_data(rb_data)
    );

    typedef struct packed {
        logic        we;
        logic [2:0]  widx;
        logic [1:0]  wview;
        logic        whi;
        logic [31:0] wdata;
        logic [2:0]  ridx;
        logic [1:0]  rview;
        logic        rhi;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NVEC = 13;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 3'd0, 2'b10, 1'b0, 32'h11223344, 3'd0, 2'b10, 1'b0, 32'h11223344, 4'd2 },  // R2
        '{1'b1, 3'd0, 2'b01, 1'b0, 32'hAAAABEEF, 3'd0, 2'b10, 1'b0, 32'h1122BEEF, 4'd3 },  // R3
        '{1'b1, 3'd0, 2'b00, 1'b0, 32'hFFFFFF5A, 3'd0, 2'b10, 1'b0, 32'h1122BE5A, 4'd4 },  // R4
        '{1'b1, 3'd0, 2'b00, 1'b1, 32'hFFFFFF77, 3'd0, 2'b10, 1'b0, 32'h1122775A, 4'd5 },  // R5
        '{1'b1, 3'd5, 2'b00, 1'b0, 32'h000000C3, 3'd1, 2'b10, 1'b0, 32'h0000C300, 4'd6 },  // R6
        '{1'b0, 3'd0, 2'b00, 1'b0, 32'h00000000, 3'd5, 2'b00, 1'b0, 32'h000000C3, 4'd6 },  // R6 read fold
        '{1'b0, 3'd0, 2'b00, 1'b0, 32'h00000000, 3'd0, 2'b01, 1'b0, 32'h0000775A, 4'd7 },  // R7
        '{1'b0, 3'd0, 2'b00, 1'b0, 32'h00000000, 3'd0, 2'b00, 1'b1, 32'h00000077, 4'd7 },  // R7
        '{1'b0, 3'd0, 2'b10, 1'b0, 32'hFFFFFFFF, 3'd0, 2'b10, 1'b0, 32'h1122775A, 4'd9 },  // R9
        '{1'b1, 3'd7, 2'b11, 1'b0, 32'hDEADBEEF, 3'd7, 2'b10, 1'b0, 32'hDEADBEEF, 4'd11},  // R11
        '{1'b1, 3'd3, 2'b10, 1'b0, 32'hCAFEF00D, 3'd3, 2'b00, 1'b1, 32'h000000F0, 4'd5 },  // R5
        '{1'b1, 3'd7, 2'b00, 1'b0, 32'h00000012, 3'd3, 2'b10, 1'b0, 32'hCAFE120D, 4'd6 },  // R6
        '{1'b1, 3'd2, 2'b00, 1'b1, 32'h00000099, 3'd2, 2'b10, 1'b0, 32'h00009900, 4'd5 }   // R5
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: all registers read zero after reset, both ports
        for (int i = 0; i < 8; i++) begin
            ra_idx = 3'(i); ra_view = 2'b10;
            rb_idx = 3'(i); rb_view = 2'b10;
            #1;
            check("R1", ra_data, 32'h0);
            check("R1", rb_data, 32'h0);
        end

        // table walk: write, then read after the edge
        for (int v = 0; v < NVEC; v++) begin
            @(negedge clk);
            wr_en = VECS[v].we; wr_idx = VECS[v].widx; wr_view = VECS[v].wview;
            wr_hi = VECS[v].whi; wr_data = VECS[v].wdata;
            ra_idx = VECS[v].ridx; ra_view = VECS[v].rview; ra_hi = VECS[v].rhi;
            @(posedge clk);
            #1;
            checks++;
            if (ra_data !== VECS[v].exp) begin
                failures++;
                $display("FAIL R%0d vec=%0d actual=%h expected=%h",
                         VECS[v].req, v, ra_data, VECS[v].exp);
            end
        end

        // R8: same-cycle read sees old value, new value after the edge
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 3'd4; wr_view = 2'b10; wr_hi = 1'b0; wr_data = 32'h0BADF00D;
        ra_idx = 3'd4; ra_view = 2'b10; ra_hi = 1'b0;
        #1;
        check("R8", ra_data, 32'h0);
        @(posedge clk);
        #1;
        check("R8", ra_data, 32'h0BADF00D);

        // R10: ports decode independently in the same cycle
        @(negedge clk);
        wr_en = 1'b0;
        ra_idx = 3'd4; ra_view = 2'b01; ra_hi = 1'b0;
        rb_idx = 3'd0; rb_view = 2'b00; rb_hi = 1'b1;
        #1;
        check("R10", ra_data, 32'h0000F00D);
        check("R10", rb_data, 32'h00000077);
        rb_idx = 3'd7; rb_view = 2'b01; rb_hi = 1'b0;
        #1;
        check("R10", rb_data, 32'h0000BEEF);

        // R1: reset again clears written registers
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        ra_idx = 3'd0; ra_view = 2'b10;
        rb_idx = 3'd7; rb_view = 2'b10;
        #1;
        check("R1", ra_data, 32'h0);
        check("R1", rb_data, 32'h0);

        done = 1'b1;
        finish_run();
    end
endmodule